// File: doc/BRIEF.md
# PS/2 Scancode to Legacy Key-Matrix Translator

This block sits behind a simple PS/2 receiver and turns its stream of scancode bytes into the 8x8 key-matrix image that a legacy computer scans. The host drives an active-low row-select vector. The block answers at once with active-low column bits. The legacy keyboard's Shift key is a separate active-low line. The translator follows release and extended prefix bytes. It keeps the physical PS/2 Shift state apart from the Shift line it presents. Each mapped key can therefore pass Shift through, assert it or suppress it, so that characters typed the modern way land on the right legacy key.

A menu mode is toggled by ScrollLock. In menu mode no key reaches the matrix. The arrow keys and Enter instead flip bits of a joystick-style register used by an on-screen menu. F11 and F12 are not matrix keys. While held, they drive two dedicated reset requests.

Top module: `kbd_matrix_xlat`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) releases every key, clears the prefix flags and both physical Shift flags, leaves menu mode, and clears the joystick register and both reset requests. After reset, col_n is 8'hFF for any row_sel_n and mtx_shift_n is 1.
- R2: col_n is combinational. Bit c is low exactly when some row r with row_sel_n[r]=0 has key (r,c) pressed, and several selected rows OR together.
- R3: Byte 8'hF0 marks the next code as a release and 8'hE0 marks it as extended. Both flags clear after the next byte that is neither of them, whether or not that code is mapped.
- R4: Key positions are given as (row,col), with the extended prefix written E0. A=1C→(4,1), B=32→(4,2), C=21→(4,3), D=23→(4,4), 0=45→(2,0), 1=16→(2,1), 2=1E→(2,2), Space=29→(7,7), Backspace=66→(0,0), Enter=5A→(0,2), Left=E0 6B→(0,5), Up=E0 75→(0,6), Right=E0 74→(0,7), Down=E0 72→(1,0), minus=4E→(3,5). 8=3E→(3,0) unshifted. Every code not listed has no effect.
- R5: The physical Shift state is true while left Shift (12) or right Shift (59), without the extended prefix, is held. For a key with natural policy, mtx_shift_n is the inverse of the physical Shift state.
- R6: Shift plus ';' (4C) presses (3,2) with the Shift line forced released (mtx_shift_n=1) even though physical Shift is held. ';' without Shift presses (3,3) with natural policy.
- R7: Shift plus '8' presses (3,2) with natural policy, so mtx_shift_n=0. '=' (55) presses (3,5) unshifted and (3,3) shifted, always with the Shift line forced (mtx_shift_n=0).
- R8: Releasing a code releases both its unshifted and shifted positions. If it was the most recently made matrix key, the Shift policy returns to natural.
- R9: Shift codes carrying the E0 prefix (make or release) leave the physical Shift state unchanged.
- R10: A ScrollLock (7E) make toggles menu_on, and its release has no effect. Entering menu mode releases every key and sets natural policy. While menu_on is 1 no key changes the matrix.
- R11: While menu_on is 1, a make of Right, Left, Up, Down or Enter toggles joy_bits bit 4, 3, 2, 1 or 0 respectively. Release codes do not toggle. With menu_on 0, joy_bits holds its value.
- R12: boot_rst is 1 while F11 (78) is held and run_rst is 1 while F12 (07) is held. Their release codes clear them, and they work in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | code_byte holds a new received byte this cycle |
| code_byte | input | 8 | Received PS/2 byte |
| row_sel_n | input | 8 | Row select from the legacy host, active low |
| col_n | output | 8 | Column readback, active low |
| mtx_shift_n | output | 1 | Legacy Shift line, active low |
| menu_on | output | 1 | Menu mode active |
| joy_bits | output | 8 | Joystick register {0,0,0,Right,Left,Up,Down,Fire} |
| boot_rst | output | 1 | Reset request with boot ROM (F11 held) |
| run_rst | output | 1 | Run reset request (F12 held) |

## Verification
The bench goes after Shift being released between a shifted make and its release. A design that forgets the shifted variant leaves the ':' key stuck down in the matrix. It sends the fake E0-prefixed Shift pair around a grey arrow. A design that obeys those codes drops a genuinely held Shift or raises a phantom one. It also checks the one-shot prefix flags by sending a mapped code right after an extended unmapped one; a sticky flag would lose that key. Finally it enters menu mode with keys held and toggles joystick bits twice. A design that does not clear or freeze the matrix there leaks keypresses to the host, and one that sets instead of toggling leaves a bit stuck.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

    localparam int KM_ROWS  = 8;
    localparam int KM_COLS  = 8;
    localparam int KM_KEYS  = KM_ROWS * KM_COLS;
    localparam int KM_IDXW  = $clog2(KM_KEYS);
    localparam int KM_JOYW  = 8;
    localparam int KM_JIDXW = $clog2(KM_JOYW);
    localparam int KM_CODEW = 8;

    localparam logic [KM_CODEW-1:0] CODE_BRK = 8'hF0;
    localparam logic [KM_CODEW-1:0] CODE_EXT = 8'hE0;

    typedef enum logic [1:0] {
        POL_NAT   = 2'd0,
        POL_FORCE = 2'd1,
        POL_NEG   = 2'd2
    } pol_e;

    typedef enum logic [2:0] {
        KD_NONE  = 3'd0,
        KD_KEY   = 3'd1,
        KD_SHIFT = 3'd2,
        KD_MENU  = 3'd3,
        KD_BOOT  = 3'd4,
        KD_RUN   = 3'd5
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        logic [KM_IDXW-1:0]   idx;
        pol_e                 pol;
        logic                 joy_hit;
        logic [KM_JIDXW-1:0]  joy_idx;
    } key_desc_t;

    typedef struct packed {
        logic brk;
        logic ext;
    } pfx_t;

    function automatic logic [KM_IDXW-1:0] kpos(input int r, input int c);
        return KM_IDXW'(r * KM_COLS + c);
    endfunction

endpackage

// File: rtl/kmx_prefix.sv
module kmx_prefix
    import kmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_vld,
    input  logic [KM_CODEW-1:0] byte_in,
    output logic                code_stb,
    output logic                brk_flag,
    output logic                ext_flag
);

    pfx_t pfx_d, pfx_q;

    always_comb begin
        pfx_d    = pfx_q;
        code_stb = 1'b0;
        if (byte_vld) begin
            if (byte_in == CODE_BRK) begin
                pfx_d.brk = 1'b1;
            end else if (byte_in == CODE_EXT) begin
                pfx_d.ext = 1'b1;
            end else begin
                code_stb  = 1'b1;
                pfx_d.brk = 1'b0;
                pfx_d.ext = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pfx_q <= '0;
        else     pfx_q <= pfx_d;
    end

    assign brk_flag = pfx_q.brk;
    assign ext_flag = pfx_q.ext;

endmodule

// File: rtl/kmx_keymap.sv
module kmx_keymap
    import kmx_pkg::*;
(
    input  logic [KM_CODEW-1:0] code,
    input  logic                ext,
    input  logic                shifted,
    output key_desc_t           desc
);

    always_comb begin
        desc         = '0;
        desc.kind    = KD_NONE;
        desc.pol     = POL_NAT;
        unique case ({ext, code})
            9'h01C: begin desc.kind = KD_KEY; desc.idx = kpos(4, 1); end
            9'h032: begin desc.kind = KD_KEY; desc.idx = kpos(4, 2); end
            9'h021: begin desc.kind = KD_KEY; desc.idx = kpos(4, 3); end
            9'h023: begin desc.kind = KD_KEY; desc.idx = kpos(4, 4); end
            9'h045: begin desc.kind = KD_KEY; desc.idx = kpos(2, 0); end
            9'h016: begin desc.kind = KD_KEY; desc.idx = kpos(2, 1); end
            9'h01E: begin desc.kind = KD_KEY; desc.idx = kpos(2, 2); end
            9'h029: begin desc.kind = KD_KEY; desc.idx = kpos(7, 7); end
            9'h066: begin desc.kind = KD_KEY; desc.idx = kpos(0, 0); end
            9'h04E: begin desc.kind = KD_KEY; desc.idx = kpos(3, 5); end
            9'h03E: begin
                desc.kind = KD_KEY;
                desc.idx  = shifted ? kpos(3, 2) : kpos(3, 0);
            end
            9'h04C: begin
                desc.kind = KD_KEY;
                desc.idx  = shifted ? kpos(3, 2) : kpos(3, 3);
                desc.pol  = shifted ? POL_NEG : POL_NAT;
            end
            9'h055: begin
                desc.kind = KD_KEY;
                desc.idx  = shifted ? kpos(3, 3) : kpos(3, 5);
                desc.pol  = POL_FORCE;
            end
            9'h05A: begin
                desc.kind = KD_KEY; desc.idx = kpos(0, 2);
                desc.joy_hit = 1'b1; desc.joy_idx = KM_JIDXW'(0);
            end
            9'h16B: begin
                desc.kind = KD_KEY; desc.idx = kpos(0, 5);
                desc.joy_hit = 1'b1; desc.joy_idx = KM_JIDXW'(3);
            end
            9'h175: begin
                desc.kind = KD_KEY; desc.idx = kpos(0, 6);
                desc.joy_hit = 1'b1; desc.joy_idx = KM_JIDXW'(2);
            end
            9'h174: begin
                desc.kind = KD_KEY; desc.idx = kpos(0, 7);
                desc.joy_hit = 1'b1; desc.joy_idx = KM_JIDXW'(4);
            end
            9'h172: begin
                desc.kind = KD_KEY; desc.idx = kpos(1, 0);
                desc.joy_hit = 1'b1; desc.joy_idx = KM_JIDXW'(1);
            end
            9'h012: begin desc.kind = KD_SHIFT; desc.idx = KM_IDXW'(0); end
            9'h059: begin desc.kind = KD_SHIFT; desc.idx = KM_IDXW'(1); end
            9'h07E: desc.kind = KD_MENU;
            9'h078: desc.kind = KD_BOOT;
            9'h007: desc.kind = KD_RUN;
            default: desc.kind = KD_NONE;
        endcase
    end

endmodule

// File: rtl/kmx_colmux.sv
module kmx_colmux #(
    parameter int NROW = 8,
    parameter int NCOL = 8
) (
    input  logic [NROW*NCOL-1:0] keys,
    input  logic [NROW-1:0]      row_sel_n,
    output logic [NCOL-1:0]      col_n
);

    for (genvar c = 0; c < NCOL; c++) begin : g_col
        logic col_hit;
        always_comb begin
            col_hit = 1'b0;
            for (int r = 0; r < NROW; r++) begin
                col_hit = col_hit | (keys[r*NCOL + c] & ~row_sel_n[r]);
            end
        end
        assign col_n[c] = ~col_hit;
    end

endmodule

// File: rtl/kbd_matrix_xlat.sv
module kbd_matrix_xlat
    import kmx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                code_valid,
    input  logic [KM_CODEW-1:0] code_byte,
    input  logic [KM_ROWS-1:0]  row_sel_n,
    output logic [KM_COLS-1:0]  col_n,
    output logic                mtx_shift_n,
    output logic                menu_on,
    output logic [KM_JOYW-1:0]  joy_bits,
    output logic                boot_rst,
    output logic                run_rst
);

    localparam int NVAR = 2;

    typedef struct packed {
        logic [KM_KEYS-1:0]  keys;
        logic                lsh;
        logic                rsh;
        pol_e                ovr;
        logic                mshift;
        logic                menu;
        logic [KM_JOYW-1:0]  joy;
        logic                boot;
        logic                run;
        logic [KM_CODEW:0]   last;
        logic                last_ok;
    } st_t;

    st_t s_d, s_q;

    logic      code_stb;
    logic      pfx_brk;
    logic      pfx_ext;
    logic      ps2_sh;
    key_desc_t kd [NVAR];
    key_desc_t dnow;
    logic [KM_KEYS-1:0] key_img;

    kmx_prefix u_pfx (
        .clk      (clk),
        .rst      (rst),
        .byte_vld (code_valid),
        .byte_in  (code_byte),
        .code_stb (code_stb),
        .brk_flag (pfx_brk),
        .ext_flag (pfx_ext)
    );

    for (genvar v = 0; v < NVAR; v++) begin : g_var
        kmx_keymap u_map (
            .code    (code_byte),
            .ext     (pfx_ext),
            .shifted (1'(v)),
            .desc    (kd[v])
        );
    end

    assign ps2_sh = s_q.lsh | s_q.rsh;
    assign dnow   = ps2_sh ? kd[1] : kd[0];

    always_comb begin
        s_d = s_q;
        if (code_stb) begin
            unique case (dnow.kind)
                KD_SHIFT: begin
                    if (dnow.idx[0]) s_d.rsh = ~pfx_brk;
                    else             s_d.lsh = ~pfx_brk;
                end
                KD_MENU: begin
                    if (!pfx_brk) begin
                        s_d.menu = ~s_q.menu;
                        if (!s_q.menu) begin
                            s_d.keys    = '0;
                            s_d.ovr     = POL_NAT;
                            s_d.last_ok = 1'b0;
                        end
                    end
                end
                KD_BOOT: s_d.boot = ~pfx_brk;
                KD_RUN:  s_d.run  = ~pfx_brk;
                KD_KEY: begin
                    if (s_q.menu) begin
                        if (!pfx_brk && dnow.joy_hit)
                            s_d.joy[dnow.joy_idx] = ~s_q.joy[dnow.joy_idx];
                    end else if (pfx_brk) begin
                        s_d.keys[kd[0].idx] = 1'b0;
                        s_d.keys[kd[1].idx] = 1'b0;
                        if (s_q.last_ok && (s_q.last == {pfx_ext, code_byte})) begin
                            s_d.ovr     = POL_NAT;
                            s_d.last_ok = 1'b0;
                        end
                    end else begin
                        s_d.keys[dnow.idx] = 1'b1;
                        s_d.ovr            = dnow.pol;
                        s_d.last           = {pfx_ext, code_byte};
                        s_d.last_ok        = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        unique case (s_d.ovr)
            POL_FORCE: s_d.mshift = 1'b1;
            POL_NEG:   s_d.mshift = 1'b0;
            default:   s_d.mshift = s_d.lsh | s_d.rsh;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q     <= '0;
            s_q.ovr <= POL_NAT;
        end else begin
            s_q     <= s_d;
        end
    end

    assign key_img = s_q.keys;

    kmx_colmux #(
        .NROW (KM_ROWS),
        .NCOL (KM_COLS)
    ) u_cols (
        .keys      (key_img),
        .row_sel_n (row_sel_n),
        .col_n     (col_n)
    );

    assign mtx_shift_n = ~s_q.mshift;
    assign menu_on     = s_q.menu;
    assign joy_bits    = s_q.joy;
    assign boot_rst    = s_q.boot;
    assign run_rst     = s_q.run;

endmodule

// File: rtl/kmx_xlat_chk.sv
module kmx_xlat_chk
    import kmx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                code_valid,
    input logic [KM_CODEW-1:0] code_byte,
    input logic                pfx_brk,
    input logic                pfx_ext,
    input logic                ps2_sh,
    input logic [KM_KEYS-1:0]  key_img,
    input logic [KM_COLS-1:0]  col_n,
    input logic                menu_on,
    input logic [KM_JOYW-1:0]  joy_bits,
    input logic                boot_rst
);

    p_idle_cols_r2: assert property (@(posedge clk) disable iff (rst)
        (key_img == '0) |-> (col_n == '1));

    p_prefix_once_r3: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code_byte != CODE_BRK && code_byte != CODE_EXT)
        |=> (!pfx_brk && !pfx_ext));

    p_fake_shift_r9: assert property (@(posedge clk) disable iff (rst)
        (code_valid && pfx_ext && (code_byte == 8'h12 || code_byte == 8'h59))
        |=> (ps2_sh == $past(ps2_sh)));

    p_menu_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        menu_on |=> (!menu_on || $stable(key_img)));

    p_joy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !menu_on |=> $stable(joy_bits));

    p_boot_release_r12: assert property (@(posedge clk) disable iff (rst)
        (code_valid && pfx_brk && !pfx_ext && code_byte == 8'h78) |=> !boot_rst);

endmodule

bind kbd_matrix_xlat kmx_xlat_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_valid (code_valid),
    .code_byte  (code_byte),
    .pfx_brk    (pfx_brk),
    .pfx_ext    (pfx_ext),
    .ps2_sh     (ps2_sh),
    .key_img    (key_img),
    .col_n      (col_n),
    .menu_on    (menu_on),
    .joy_bits   (joy_bits),
    .boot_rst   (boot_rst)
);

// File: tb/kbd_matrix_xlat_tb_top.sv
module kbd_matrix_xlat_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_valid = 1'b0;
    logic [7:0] code_byte = 8'h00;
    logic [7:0] row_sel_n = 8'hFF;
    logic [7:0] col_n;
    logic       mtx_shift_n;
    logic       menu_on;
    logic [7:0] joy_bits;
    logic       boot_rst;
    logic       run_rst;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  hold  = 0;
    bit  done  = 0;

    // reference model state
    bit       m_key [64];
    bit       m_brk, m_ext, m_lsh, m_rsh, m_menu, m_boot, m_run;
    int       m_ovr;          // 0 natural, 1 forced, 2 negated
    bit [7:0] m_joy;
    int       m_last;         // -1 none

    always #5 clk = ~clk;

    kbd_matrix_xlat dut_i (
        .clk (clk), .rst (rst), .code_valid (code_valid), .code_byte (code_byte),
        .row_sel_n (row_sel_n), .col_n (col_n), .mtx_shift_n (mtx_shift_n),
        .menu_on (menu_on), .joy_bits (joy_bits), .boot_rst (boot_rst), .run_rst (run_rst)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rc(input int r, input int c);
        return r * 8 + c;
    endfunction

    // key position per R4, R6, R7; returns -1 for no matrix key
    function automatic int lookup(input bit ext, input int code, input bit sh,
                                  output int pol);
        pol = 0;
        if (!ext) begin
            case (code)
                'h1C: return rc(4,1);  'h32: return rc(4,2);
                'h21: return rc(4,3);  'h23: return rc(4,4);
                'h45: return rc(2,0);  'h16: return rc(2,1);
                'h1E: return rc(2,2);  'h29: return rc(7,7);
                'h66: return rc(0,0);  'h4E: return rc(3,5);
                'h5A: return rc(0,2);
                'h3E: return sh ? rc(3,2) : rc(3,0);
                'h4C: begin pol = sh ? 2 : 0; return sh ? rc(3,2) : rc(3,3); end
                'h55: begin pol = 1; return sh ? rc(3,3) : rc(3,5); end
                default: return -1;
            endcase
        end
        case (code)
            'h6B: return rc(0,5);  'h75: return rc(0,6);
            'h74: return rc(0,7);  'h72: return rc(1,0);
            default: return -1;
        endcase
    endfunction

    function automatic int joyidx(input bit ext, input int code);
        if (!ext && code == 'h5A) return 0;
        if (ext && code == 'h72) return 1;
        if (ext && code == 'h75) return 2;
        if (ext && code == 'h6B) return 3;
        if (ext && code == 'h74) return 4;
        return -1;
    endfunction

    task automatic m_reset();
        foreach (m_key[i]) m_key[i] = 0;
        m_brk = 0; m_ext = 0; m_lsh = 0; m_rsh = 0; m_menu = 0;
        m_boot = 0; m_run = 0; m_ovr = 0; m_joy = 0; m_last = -1;
    endtask

    task automatic m_step(input int b);
        int p0, p1, pn, k0, k1, kn, ji, id;
        if (b == 'hF0) begin m_brk = 1; return; end
        if (b == 'hE0) begin m_ext = 1; return; end
        id = (m_ext ? 256 : 0) + b;
        if (!m_ext && (b == 'h12 || b == 'h59)) begin
            if (b == 'h12) m_lsh = !m_brk; else m_rsh = !m_brk;
        end else if (!m_ext && b == 'h7E) begin
            if (!m_brk) begin
                m_menu = !m_menu;
                if (m_menu) begin
                    foreach (m_key[i]) m_key[i] = 0;
                    m_ovr = 0; m_last = -1;
                end
            end
        end else if (!m_ext && b == 'h78) m_boot = !m_brk;
        else if (!m_ext && b == 'h07) m_run = !m_brk;
        else begin
            k0 = lookup(m_ext, b, 0, p0);
            k1 = lookup(m_ext, b, 1, p1);
            kn = lookup(m_ext, b, m_lsh | m_rsh, pn);
            if (kn >= 0) begin
                if (m_menu) begin
                    ji = joyidx(m_ext, b);
                    if (!m_brk && ji >= 0) m_joy[ji] = ~m_joy[ji];
                end else if (m_brk) begin
                    m_key[k0] = 0; m_key[k1] = 0;
                    if (m_last == id) begin m_ovr = 0; m_last = -1; end
                end else begin
                    m_key[kn] = 1; m_ovr = pn; m_last = id;
                end
            end
        end
        m_brk = 0; m_ext = 0;
    endtask

    function automatic bit m_shift();
        if (m_ovr == 1) return 1;
        if (m_ovr == 2) return 0;
        return m_lsh | m_rsh;
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        logic [7:0] ec;
        #3;
        if (!rst && !done) begin
            ec = 8'hFF;
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++)
                    if (!row_sel_n[r] && m_key[rc(r,c)]) ec[c] = 1'b0;
            chk("R2 col_n", col_n, ec);
            chk("R5 mtx_shift_n", {7'd0, mtx_shift_n}, {7'd0, !m_shift()});
            chk("R10 menu_on", {7'd0, menu_on}, {7'd0, m_menu});
            chk("R11 joy_bits", joy_bits, m_joy);
            chk("R12 resets", {6'd0, boot_rst, run_rst}, {6'd0, m_boot, m_run});
        end
    end

    // row scanner
    initial begin
        int sc = 0;
        forever begin
            @(negedge clk);
            if (!hold) begin
                sc = (sc + 1) % 9;
                row_sel_n = (sc == 8) ? 8'h00 : ~(8'h01 << sc);
            end
        end
    end

    task automatic send(input int b);
        @(negedge clk);
        code_valid = 1'b1;
        code_byte  = 8'(b);
        @(posedge clk);
        m_step(b);
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic look(input logic [7:0] rs);
        hold = 1;
        #2;
        row_sel_n = rs;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_reset();
        do_reset();
        // R1: reset state
        look(8'h00);
        chk("R1 col_n after reset", col_n, 8'hFF);
        chk("R1 shift/menu/boot/run", {4'd0, mtx_shift_n, menu_on, boot_rst, run_rst}, 8'h08);
        chk("R1 joy_bits", joy_bits, 8'h00);
        hold = 0;

        // R4: single key A at (4,1)
        send('h1C);
        look(~8'h10);
        chk("R4 A at row4", col_n, 8'hFD);
        hold = 0;
        send('hF0); send('h1C);

        // R2: several rows OR together
        send('h1C); send('h32); send('h23); send('h16);
        look(8'h00);
        chk("R2 all rows", col_n, 8'hE9);
        look(~8'h04);
        chk("R2 row2 only", col_n, 8'hFD);
        hold = 0;
        send('hF0); send('h1C); send('hF0); send('h32);
        send('hF0); send('h23); send('hF0); send('h16);

        // R5/R6: Shift + ';' -> (3,2), Shift suppressed
        send('h12);
        chk("R5 shift held", {7'd0, mtx_shift_n}, 8'h00);
        send('h4C);
        look(~8'h08);
        chk("R6 colon key", col_n, 8'hFB);
        chk("R6 shift negated", {7'd0, mtx_shift_n}, 8'h01);
        hold = 0;
        send('hF0); send('h4C);
        chk("R8 natural again", {7'd0, mtx_shift_n}, 8'h00);
        send('hF0); send('h12);

        // R7/R8: Shift + '8', release Shift first
        send('h59); send('h3E);
        look(~8'h08);
        chk("R7 star via colon", col_n, 8'hFB);
        chk("R7 shift natural", {7'd0, mtx_shift_n}, 8'h00);
        hold = 0;
        send('hF0); send('h59);
        chk("R5 shift dropped", {7'd0, mtx_shift_n}, 8'h01);
        send('hF0); send('h3E);
        look(~8'h08);
        chk("R8 both variants released", col_n, 8'hFF);
        hold = 0;

        // R7: '=' forces Shift
        send('h55);
        chk("R7 forced shift", {7'd0, mtx_shift_n}, 8'h00);
        send('hF0); send('h55);

        // R9: fake shift pair around a grey arrow
        send('hE0); send('h12); send('hE0); send('h75);
        chk("R9 fake make ignored", {7'd0, mtx_shift_n}, 8'h01);
        send('hE0); send('hF0); send('h75); send('hE0); send('hF0); send('h12);
        send('h12); send('hE0); send('hF0); send('h12);
        chk("R9 fake break ignored", {7'd0, mtx_shift_n}, 8'h00);
        send('hF0); send('h12);

        // R3: extended flag is one-shot
        send('hE0); send('h1C);
        look(~8'h10);
        chk("R3 extended A unmapped", col_n, 8'hFF);
        hold = 0;
        send('h1C);
        look(~8'h10);
        chk("R3 flag cleared", col_n, 8'hFD);
        hold = 0;

        // R10/R11: menu mode
        send('h7E);
        look(8'h00);
        chk("R10 matrix cleared", col_n, 8'hFF);
        hold = 0;
        send('hF0); send('h7E);
        chk("R10 release no toggle", {7'd0, menu_on}, 8'h01);
        send('h29);
        send('hE0); send('h74); send('h5A); send('hE0); send('h75);
        chk("R11 toggles", joy_bits, 8'h15);
        send('hE0); send('hF0); send('h74);
        send('hE0); send('h74);
        chk("R11 second toggle", joy_bits, 8'h05);
        send('h7E);
        send('h5A);
        chk("R11 held outside menu", joy_bits, 8'h05);
        send('hF0); send('h5A);

        // R12: dedicated resets
        send('h78);
        chk("R12 boot_rst", {7'd0, boot_rst}, 8'h01);
        send('hF0); send('h78);
        send('h07);
        chk("R12 run_rst", {6'd0, boot_rst, run_rst}, 8'h01);
        send('hF0); send('h07);

        // R1: reset from a busy state
        send('h12); send('h29); send('hE0); send('h75);
        do_reset();
        look(8'h00);
        chk("R1 col_n after second reset", col_n, 8'hFF);
        chk("R1 joy after second reset", joy_bits, 8'h00);
        hold = 0;

        repeat (20) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule